// File: doc/BRIEF.md
# In-Order Pipeline Stage-Advance Controller

This block steers the occupancy of a five-stage in-order pipeline made up of fetch, decode, execute, memory and write-back slots. Each slot holds a valid bit, an instruction tag, a destination register, two source registers and an instruction class. In every cycle the controller decides which slots take a new instruction, which keep theirs and which become empty. A fetch port offers decoded instructions. An external register scoreboard reports through one ready bit whether the source registers of the instruction in decode are available.

The execute slot is held for a class-dependent number of cycles, and a small state machine tracks it. This machine has three states. `EXS_EMPTY` means execute holds nothing. `EXS_BUSY` means the instruction is still running, with a down-counter holding the cycles that remain. `EXS_DONE` means the instruction leaves execute at the next clock edge. The transitions are:
- `EXS_EMPTY` to `EXS_DONE` or `EXS_BUSY` on an issue, depending on the latency.
- `EXS_BUSY` to `EXS_DONE` when the counter reaches zero.
- `EXS_DONE` to `EXS_EMPTY` when there is no issue, or to `EXS_DONE` or `EXS_BUSY` on a back-to-back issue.

While execute is busy, the memory slot receives bubbles and decode and fetch back up. Memory and write-back keep draining.

Top module: `inorder_stall_ctrl`

## Requirements
- R1: A synchronous reset empties all five slots (valid 0, tag 0, destination 0), sets `cycle_cnt` to 0, and drives `drained` to 1 and `fetch_ready` to 1.
- R2: An instruction of class ALU (0), load (3) or store (4) stays in execute for exactly 1 cycle. Class codes 5 to 7 behave like ALU.
- R3: An instruction of class multiply (1) stays in execute for exactly 13 cycles. Counting starts on the cycle after it leaves decode.
- R4: An instruction of class divide/remainder (2) stays in execute for exactly 36 cycles.
- R5: While the execute instruction has not finished, `stall_ex` is 1, the memory slot is empty in the next cycle, and decode does not issue.
- R6: Each clock edge moves the memory slot unchanged into write-back. The old write-back contents are always discarded.
- R7: Decode issues into execute only when `sb_ready` is 1 and execute is free or leaving. Otherwise `stall_id` is 1 and the decode and fetch slots keep their contents.
- R8: The fetch slot moves into decode only when decode is empty or issuing. `fetch_ready` is 1 exactly when the fetch slot will be empty after this edge. An instruction is captured only when `fetch_valid` and `fetch_ready` are both 1.
- R9: `drained` is 1 exactly when all five slots are empty.
- R10: `cycle_cnt` increases by one on every clock edge after reset and wraps at its width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | A program instruction is offered |
| fetch_tag | input | TAG_W | Tag of the offered instruction (non-zero) |
| fetch_dst | input | REG_W | Destination register |
| fetch_src1 | input | REG_W | First source register |
| fetch_src2 | input | REG_W | Second source register |
| fetch_cls | input | 3 | Class: 0 ALU, 1 multiply, 2 divide/remainder, 3 load, 4 store |
| sb_ready | input | 1 | Scoreboard: both decode sources are available |
| fetch_ready | output | 1 | The offered instruction is taken this cycle |
| stg_valid | output | 5 | Valid bits; bit 0 fetch, 1 decode, 2 execute, 3 memory, 4 write-back |
| stg_tag | output | 5*TAG_W | Tags; slice i belongs to stage i |
| stg_dst | output | 5*REG_W | Destination registers; slice i belongs to stage i |
| id_src1 | output | REG_W | First source of the decode instruction |
| id_src2 | output | REG_W | Second source of the decode instruction |
| stall_id | output | 1 | Decode holds a valid instruction that does not issue |
| stall_ex | output | 1 | Execute holds an unfinished instruction |
| drained | output | 1 | All slots are empty |
| cycle_cnt | output | CYC_W | Cycles since reset |

## Verification
The hardest situation to reach is a scoreboard stall that overlaps a long execute occupancy. In that case decode is held for two separate reasons, and the release of one must not let decode issue while the other still holds. A divide followed at once by another long instruction is a second hard case, because execute must reload in its done cycle without an empty gap. The stimulus mixes such instructions into one program while `sb_ready` follows a periodic pattern with multi-cycle drops. A behavioural model tracks the execute deadline as an absolute cycle number and is compared on every clock. The time each tag spends in execute is also measured from the ports.

// File: rtl/isc_pkg.sv
package isc_pkg;
    localparam int TAG_W = 8;
    localparam int REG_W = 5;
    localparam int NSTG  = 5;

    localparam int S_IF  = 0;
    localparam int S_ID  = 1;
    localparam int S_EX  = 2;
    localparam int S_MEM = 3;
    localparam int S_WB  = 4;

    typedef enum logic [2:0] {
        CL_ALU   = 3'd0,
        CL_MUL   = 3'd1,
        CL_DIV   = 3'd2,
        CL_LOAD  = 3'd3,
        CL_STORE = 3'd4
    } iclass_e;

    typedef enum logic [1:0] {
        EXS_EMPTY = 2'd0,
        EXS_BUSY  = 2'd1,
        EXS_DONE  = 2'd2
    } exs_e;

    typedef struct packed {
        logic             v;
        logic [TAG_W-1:0] tag;
        logic [REG_W-1:0] dst;
        logic [REG_W-1:0] s1;
        logic [REG_W-1:0] s2;
        logic [2:0]       cls;
    } slot_t;
endpackage

// File: rtl/pipe_slot.sv
module pipe_slot
    import isc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ld,
    input  logic  clr,
    input  slot_t d,
    output slot_t q
);
    always_ff @(posedge clk) begin
        if (rst)      q <= '0;
        else if (ld)  q <= d;
        else if (clr) q <= '0;
    end
endmodule

// File: rtl/ex_occupancy.sv
module ex_occupancy
    import isc_pkg::*;
#(
    parameter int LAT_MUL   = 13,
    parameter int LAT_DIV   = 36,
    parameter int LAT_OTHER = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       issue,
    input  logic [2:0] cls,
    output logic       busy,
    output logic       done
);
    localparam int LAT_MAX = (LAT_DIV > LAT_MUL) ? LAT_DIV : LAT_MUL;
    localparam int CW      = $clog2(LAT_MAX + 1);

    exs_e          state, state_n;
    logic [CW-1:0] cnt, cnt_n;

    function automatic int lat_of(input logic [2:0] c);
        unique case (c)
            CL_MUL:  lat_of = LAT_MUL;
            CL_DIV:  lat_of = LAT_DIV;
            default: lat_of = LAT_OTHER;
        endcase
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= EXS_EMPTY;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    always_comb begin
        int lat;
        lat     = lat_of(cls);
        state_n = state;
        cnt_n   = cnt;
        unique case (state)
            EXS_EMPTY, EXS_DONE: begin
                if (issue) begin
                    if (lat <= 1) begin
                        state_n = EXS_DONE;
                        cnt_n   = '0;
                    end else begin
                        state_n = EXS_BUSY;
                        cnt_n   = CW'(lat - 2);
                    end
                end else begin
                    state_n = EXS_EMPTY;
                end
            end
            EXS_BUSY: begin
                if (cnt == '0) state_n = EXS_DONE;
                else           cnt_n   = cnt - 1'b1;
            end
            default: state_n = EXS_EMPTY;
        endcase
    end

    always_comb begin
        busy = (state == EXS_BUSY);
        done = (state == EXS_DONE);
    end

    AST_BUSY_STAYS: assert property (@(posedge clk) disable iff (rst)
        (state == EXS_BUSY && cnt != '0) |=> state == EXS_BUSY); // R3
    AST_DONE_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        (state == EXS_DONE && !issue) |=> state == EXS_EMPTY); // R2
    AST_NO_ISSUE_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |-> !issue); // R5
endmodule

// File: rtl/inorder_stall_ctrl.sv
module inorder_stall_ctrl
    import isc_pkg::*;
#(
    parameter int CYC_W     = 16,
    parameter int LAT_MUL   = 13,
    parameter int LAT_DIV   = 36,
    parameter int LAT_OTHER = 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   fetch_valid,
    input  logic [TAG_W-1:0]       fetch_tag,
    input  logic [REG_W-1:0]       fetch_dst,
    input  logic [REG_W-1:0]       fetch_src1,
    input  logic [REG_W-1:0]       fetch_src2,
    input  logic [2:0]             fetch_cls,
    input  logic                   sb_ready,
    output logic                   fetch_ready,
    output logic [NSTG-1:0]        stg_valid,
    output logic [NSTG*TAG_W-1:0]  stg_tag,
    output logic [NSTG*REG_W-1:0]  stg_dst,
    output logic [REG_W-1:0]       id_src1,
    output logic [REG_W-1:0]       id_src2,
    output logic                   stall_id,
    output logic                   stall_ex,
    output logic                   drained,
    output logic [CYC_W-1:0]       cycle_cnt
);
    slot_t q   [NSTG];
    slot_t d   [NSTG];
    logic  ld  [NSTG];
    logic  clr [NSTG];

    slot_t fetch_slot, mem_in;
    logic  ex_busy, ex_done, ex_free, id_issue, if_moves, fetch_fire;

    assign fetch_slot = '{v: 1'b1, tag: fetch_tag, dst: fetch_dst,
                          s1: fetch_src1, s2: fetch_src2, cls: fetch_cls};

    ex_occupancy #(
        .LAT_MUL   (LAT_MUL),
        .LAT_DIV   (LAT_DIV),
        .LAT_OTHER (LAT_OTHER)
    ) ex_occ_i (
        .clk   (clk),
        .rst   (rst),
        .issue (id_issue),
        .cls   (q[S_ID].cls),
        .busy  (ex_busy),
        .done  (ex_done)
    );

    // Advance decisions, evaluated from the back of the pipe forward
    assign ex_free     = !q[S_EX].v || ex_done;
    assign id_issue    = q[S_ID].v && ex_free && sb_ready;
    assign if_moves    = q[S_IF].v && (!q[S_ID].v || id_issue);
    assign fetch_ready = !q[S_IF].v || if_moves;
    assign fetch_fire  = fetch_ready && fetch_valid;
    assign mem_in      = ex_done ? q[S_EX] : '0;

    assign d[S_IF]    = fetch_slot;
    assign ld[S_IF]   = fetch_fire;
    assign clr[S_IF]  = if_moves;
    assign d[S_ID]    = q[S_IF];
    assign ld[S_ID]   = if_moves;
    assign clr[S_ID]  = id_issue;
    assign d[S_EX]    = q[S_ID];
    assign ld[S_EX]   = id_issue;
    assign clr[S_EX]  = ex_done;
    assign d[S_MEM]   = mem_in;
    assign ld[S_MEM]  = 1'b1;
    assign clr[S_MEM] = 1'b0;
    assign d[S_WB]    = q[S_MEM];
    assign ld[S_WB]   = 1'b1;
    assign clr[S_WB]  = 1'b0;

    for (genvar i = 0; i < NSTG; i++) begin : g_stage
        pipe_slot slot_i (
            .clk (clk),
            .rst (rst),
            .ld  (ld[i]),
            .clr (clr[i]),
            .d   (d[i]),
            .q   (q[i])
        );
        assign stg_valid[i]              = q[i].v;
        assign stg_tag[i*TAG_W +: TAG_W] = q[i].tag;
        assign stg_dst[i*REG_W +: REG_W] = q[i].dst;
    end

    assign id_src1  = q[S_ID].s1;
    assign id_src2  = q[S_ID].s2;
    assign stall_id = q[S_ID].v && !id_issue;
    assign stall_ex = ex_busy;
    assign drained  = ~|stg_valid;

    always_ff @(posedge clk) begin
        if (rst) cycle_cnt <= '0;
        else     cycle_cnt <= cycle_cnt + 1'b1;
    end

    AST_MEM_BUBBLE: assert property (@(posedge clk) disable iff (rst)
        (q[S_EX].v && !ex_done) |=> !q[S_MEM].v); // R5
    AST_ID_HELD_BY_EX: assert property (@(posedge clk) disable iff (rst)
        (q[S_ID].v && ex_busy) |=> q[S_ID].v && q[S_ID].tag == $past(q[S_ID].tag)); // R5
    AST_WB_FOLLOWS_MEM: assert property (@(posedge clk) disable iff (rst)
        q[S_MEM].v |=> q[S_WB].v && q[S_WB].tag == $past(q[S_MEM].tag)); // R6
    AST_ID_WAITS_SB: assert property (@(posedge clk) disable iff (rst)
        (q[S_ID].v && !sb_ready) |=> q[S_ID].v && $stable(q[S_ID].tag)); // R7
    AST_IF_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (q[S_IF].v && stall_id) |=> q[S_IF].v && $stable(q[S_IF].tag)); // R8
    AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> cycle_cnt == CYC_W'($past(cycle_cnt) + 1'b1)); // R10
endmodule

// File: tb/inorder_stall_ctrl_tb_top.sv
module inorder_stall_ctrl_tb_top;
    import isc_pkg::*;

    localparam int NP  = 22;
    localparam int CYW = 16;

    logic                  clk = 1'b0;
    logic                  rst;
    logic                  fetch_valid;
    logic [TAG_W-1:0]      fetch_tag;
    logic [REG_W-1:0]      fetch_dst, fetch_src1, fetch_src2;
    logic [2:0]            fetch_cls;
    logic                  sb_ready;
    logic                  fetch_ready;
    logic [NSTG-1:0]       stg_valid;
    logic [NSTG*TAG_W-1:0] stg_tag;
    logic [NSTG*REG_W-1:0] stg_dst;
    logic [REG_W-1:0]      id_src1, id_src2;
    logic                  stall_id, stall_ex, drained;
    logic [CYW-1:0]        cycle_cnt;

    always #2 clk = ~clk;

    inorder_stall_ctrl #(.CYC_W(CYW)) dut_i (
        .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_tag(fetch_tag),
        .fetch_dst(fetch_dst), .fetch_src1(fetch_src1), .fetch_src2(fetch_src2),
        .fetch_cls(fetch_cls), .sb_ready(sb_ready), .fetch_ready(fetch_ready),
        .stg_valid(stg_valid), .stg_tag(stg_tag), .stg_dst(stg_dst),
        .id_src1(id_src1), .id_src2(id_src2), .stall_id(stall_id),
        .stall_ex(stall_ex), .drained(drained), .cycle_cnt(cycle_cnt)
    );

    int checks = 0;
    int errors = 0;

    // program
    int p_cls [NP] = '{0,3,1,0,4,2,0,0,3,1,1,0,2,4,0,7,0,1,0,2,2,0};
    // model state
    bit mv [5];
    int mtag [5], mdst [5], mcls [5];
    int ms1, ms2, mcyc, ex_due, pidx;
    // residency tracking
    bit pv; int ptag, plen;

    function automatic int lat_of(int c);
        if (c == 1) return 13;
        if (c == 2) return 36;
        return 1;
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit m_empty();
        foreach (mv[i]) if (mv[i]) return 1'b0;
        return 1'b1;
    endfunction

    task automatic cmp_regs();
        string rq [5] = '{"R8", "R8", "R5", "R5", "R6"};
        for (int i = 0; i < 5; i++) begin
            chk(stg_valid[i] == mv[i], rq[i], $sformatf("valid[%0d]", i), stg_valid[i], mv[i]);
            chk(int'(stg_tag[i*TAG_W +: TAG_W]) == mtag[i], rq[i], $sformatf("tag[%0d]", i),
                stg_tag[i*TAG_W +: TAG_W], mtag[i]);
            chk(int'(stg_dst[i*REG_W +: REG_W]) == mdst[i], rq[i], $sformatf("dst[%0d]", i),
                stg_dst[i*REG_W +: REG_W], mdst[i]);
        end
        if (mv[1]) begin
            chk(int'(id_src1) == ms1 && int'(id_src2) == ms2, "R7", "id sources",
                {id_src1, id_src2}, (ms1 << REG_W) | ms2);
        end
        chk(drained == m_empty(), "R9", "drained", drained, m_empty());
        chk(int'(cycle_cnt) == (mcyc % (1 << CYW)), "R10", "cycle_cnt", cycle_cnt, mcyc % (1 << CYW));
    endtask

    task automatic track_ex();
        bit cv; int ct;
        cv = stg_valid[2];
        ct = int'(stg_tag[2*TAG_W +: TAG_W]);
        if (pv && (!cv || ct != ptag)) begin
            int c = p_cls[ptag-1];
            if (c == 1)      chk(plen == 13, "R3", "mul residency", plen, 13);
            else if (c == 2) chk(plen == 36, "R4", "div residency", plen, 36);
            else             chk(plen == 1, "R2", "single-cycle residency", plen, 1);
        end
        if (cv && (!pv || ct != ptag)) plen = 1;
        else if (cv)                   plen++;
        pv = cv; ptag = ct;
    endtask

    initial begin
        int wd;
        rst = 1'b1; fetch_valid = 1'b0; fetch_tag = '0; fetch_dst = '0;
        fetch_src1 = '0; fetch_src2 = '0; fetch_cls = '0; sb_ready = 1'b0;
        foreach (mv[i]) begin mv[i] = 0; mtag[i] = 0; mdst[i] = 0; mcls[i] = 0; end
        ms1 = 0; ms2 = 0; mcyc = 0; ex_due = 0; pidx = 0; pv = 0; ptag = 0; plen = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // reset state
        chk(stg_valid == '0, "R1", "reset valid", stg_valid, 0);
        chk(stg_tag == '0, "R1", "reset tags", stg_tag, 0);
        chk(drained == 1'b1, "R1", "reset drained", drained, 1);
        chk(fetch_ready == 1'b1, "R1", "reset fetch_ready", fetch_ready, 1);
        chk(cycle_cnt == '0, "R1", "reset cycle_cnt", cycle_cnt, 0);
        rst = 1'b0;
        wd = 0;
        while (pidx < NP || !m_empty() || wd < 5) begin
            bit leave, efree, iss, ifm, fr, fire;
            bit nv [5]; int nt [5], nd [5], nc [5];
            int ns1, ns2;
            wd++;
            if (wd > 5000) begin
                chk(1'b0, "R9", "watchdog", wd, 0);
                break;
            end
            cmp_regs();
            track_ex();
            // drive
            fetch_valid = (pidx < NP);
            if (pidx < NP) begin
                fetch_tag  = TAG_W'(pidx + 1);
                fetch_dst  = REG_W'((pidx * 7 + 3) % 32);
                fetch_src1 = REG_W'((pidx * 5 + 1) % 32);
                fetch_src2 = REG_W'((pidx * 3 + 2) % 32);
                fetch_cls  = 3'(p_cls[pidx]);
            end
            sb_ready = !((mcyc % 9) >= 2 && (mcyc % 9) <= 4);
            #1;
            // model decisions
            leave = mv[2] && (mcyc >= ex_due);
            efree = !mv[2] || leave;
            iss   = mv[1] && efree && sb_ready;
            ifm   = mv[0] && (!mv[1] || iss);
            fr    = !mv[0] || ifm;
            fire  = fr && fetch_valid;
            chk(fetch_ready == fr, "R8", "fetch_ready", fetch_ready, fr);
            chk(stall_id == (mv[1] && !iss), "R7", "stall_id", stall_id, mv[1] && !iss);
            chk(stall_ex == (mv[2] && !leave), "R5", "stall_ex", stall_ex, mv[2] && !leave);
            // next state
            nv[4] = mv[3]; nt[4] = mtag[3]; nd[4] = mdst[3]; nc[4] = mcls[3];
            if (leave) begin nv[3] = 1; nt[3] = mtag[2]; nd[3] = mdst[2]; nc[3] = mcls[2]; end
            else       begin nv[3] = 0; nt[3] = 0; nd[3] = 0; nc[3] = 0; end
            if (iss) begin
                nv[2] = 1; nt[2] = mtag[1]; nd[2] = mdst[1]; nc[2] = mcls[1];
                ex_due = mcyc + lat_of(mcls[1]);
            end else if (leave) begin nv[2] = 0; nt[2] = 0; nd[2] = 0; nc[2] = 0; end
            else begin nv[2] = mv[2]; nt[2] = mtag[2]; nd[2] = mdst[2]; nc[2] = mcls[2]; end
            ns1 = ms1; ns2 = ms2;
            if (ifm) begin
                nv[1] = 1; nt[1] = mtag[0]; nd[1] = mdst[0]; nc[1] = mcls[0];
                ns1 = (pidx_of(mtag[0]) * 5 + 1) % 32; ns2 = (pidx_of(mtag[0]) * 3 + 2) % 32;
            end else if (iss) begin nv[1] = 0; nt[1] = 0; nd[1] = 0; nc[1] = 0; ns1 = 0; ns2 = 0; end
            else begin nv[1] = mv[1]; nt[1] = mtag[1]; nd[1] = mdst[1]; nc[1] = mcls[1]; end
            if (fire) begin
                nv[0] = 1; nt[0] = pidx + 1; nd[0] = (pidx * 7 + 3) % 32; nc[0] = p_cls[pidx];
            end else if (ifm) begin nv[0] = 0; nt[0] = 0; nd[0] = 0; nc[0] = 0; end
            else begin nv[0] = mv[0]; nt[0] = mtag[0]; nd[0] = mdst[0]; nc[0] = mcls[0]; end
            @(posedge clk);
            foreach (mv[i]) begin mv[i] = nv[i]; mtag[i] = nt[i]; mdst[i] = nd[i]; mcls[i] = nc[i]; end
            ms1 = ns1; ms2 = ns2;
            if (fire) pidx++;
            mcyc++;
            if (pidx == NP && m_empty() && wd < 5000) wd = (wd < 5) ? wd : wd;
            @(negedge clk);
        end
        cmp_regs();
        chk(drained == 1'b1, "R9", "final drained", drained, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    function automatic int pidx_of(int tag);
        return tag - 1;
    endfunction
endmodule